// File: doc/BRIEF.md
# Context-Tagged Indirect Branch Target Buffer

This block predicts the destination of indirect branches for a two-thread fetch unit. It keeps a small direct-mapped array of discrete per-branch entries. Each entry records the resolved target, a partial PC tag, and the context that trained it: the privilege level (kernel or user) and the hardware thread. A lookup returns a predicted target only when the entry was trained by a matching context. Because of this, code in one context cannot steer predictions made for another.

Isolation is governed by three configuration inputs. Two of them enable the privilege check and the thread check independently. The third enables sanitizing on context transitions. A parameter can instead force both checks on permanently. Two events clear every entry in a single clock: a context-transition pulse, when it is enabled, and a software-issued predictor barrier, which always acts. The lookup path is combinational from the stored array. Updates and flushes take effect at the next rising edge.

Top module: `ctx_ibtb`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, so every lookup reports a miss with a target of 0.
- R2: A lookup uses `lk_pc[5:2]` as the entry index and `lk_pc[13:6]` as the tag. A hit needs a valid entry whose stored tag equals the lookup tag, and it returns the stored target. A miss drives `lk_hit` to 0 and `lk_target` to 0.
- R3: When `up_en` is 1, the entry at index `up_pc[5:2]` is written or overwritten with tag `up_pc[13:6]`, target `up_target`, privilege `up_kmode` and thread `up_tid`. The new content is seen by lookups from the next cycle onward.
- R4: When `cfg_mode_iso` is 1 (or the policy parameter forces isolation), a hit also needs the stored privilege bit to equal `lk_kmode` (1 = kernel, 0 = user).
- R5: When `cfg_thread_iso` is 1 (or the policy forces isolation), a hit also needs the stored thread ID to equal `lk_tid`.
- R6: When a check is disabled by configuration, an entry trained in one privilege level or thread hits for a lookup from the other. Cross-context hits occur only in that case.
- R7: `sw_barrier` clears every entry at the next edge. A lookup in the same cycle reports a miss.
- R8: `ctx_switch` with `cfg_switch_flush_en` set clears every entry just as the barrier does, including the same-cycle miss. With the enable at 0, `ctx_switch` has no effect.
- R9: An update in the same cycle as a flush is dropped.
- R10: A lookup in the same cycle as an update to its entry sees the entry's previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Fetch PC of the indirect branch being predicted |
| lk_kmode | input | 1 | Requester privilege level, 1 = kernel |
| lk_tid | input | 1 | Requesting hardware thread |
| lk_hit | output | 1 | Prediction valid |
| lk_target | output | 32 | Predicted target, 0 on a miss |
| up_en | input | 1 | Write a resolved indirect branch |
| up_pc | input | 32 | PC of the resolved branch |
| up_target | input | 32 | Resolved target |
| up_kmode | input | 1 | Privilege level of the training code |
| up_tid | input | 1 | Thread of the training code |
| ctx_switch | input | 1 | Context transition pulse, for example system-call entry |
| sw_barrier | input | 1 | Software predictor barrier command |
| cfg_mode_iso | input | 1 | Enable privilege tag checking |
| cfg_thread_iso | input | 1 | Enable thread tag checking |
| cfg_switch_flush_en | input | 1 | Enable flush on context transition |

## Verification
The assertions assume that the configuration bits and the flush inputs are valid for the whole cycle in which they are sampled, because the same-cycle miss and the tag-match checks are written against their current values. They also assume that the flush inputs carry known values while reset is held, since the post-flush checks look one cycle back. The stimulus changes every input only on the falling edge. It holds all controls at 0 during reset. Random traffic draws PCs from two tags across all sixteen indexes, so entries alias and hit often, while barriers, transitions and configuration changes are mixed in at low rates.

// File: rtl/ctx_ibtb_pkg.sv
// Shared types for the context-tagged indirect target buffer.
package ctx_ibtb_pkg;
    // How tag isolation is decided: from configuration inputs, or forced on.
    typedef enum logic {
        ISO_CFG    = 1'b0,
        ISO_FORCED = 1'b1
    } iso_policy_e;
endpackage

// File: rtl/ctx_ibtb_ctl.sv
// Isolation and sanitize control.
// Turns the transition pulse, the barrier command and the configuration
// bits into one flush strobe and the effective tag-check enables.
// Assumes all inputs are synchronous to the buffer clock.
module ctx_ibtb_ctl
    import ctx_ibtb_pkg::*;
#(
    parameter iso_policy_e POLICY = ISO_CFG
) (
    input  logic cfg_mode_iso,
    input  logic cfg_thread_iso,
    input  logic cfg_switch_flush_en,
    input  logic ctx_switch,
    input  logic sw_barrier,
    output logic flush,
    output logic mode_chk,
    output logic thread_chk
);
    // Flush request: barrier always, transition only when enabled.
    always_comb flush = sw_barrier | (ctx_switch & cfg_switch_flush_en);

    generate
        if (POLICY == ISO_FORCED) begin : g_forced
            logic unused_cfg;
            assign unused_cfg = cfg_mode_iso ^ cfg_thread_iso;
            // Isolation permanently enforced.
            assign mode_chk   = 1'b1;
            assign thread_chk = 1'b1;
        end else begin : g_cfg
            // Isolation chosen by configuration bits.
            assign mode_chk   = cfg_mode_iso;
            assign thread_chk = cfg_thread_iso;
        end
    endgenerate
endmodule

// File: rtl/ctx_ibtb_store.sv
// Entry storage for the target buffer.
// Direct-mapped array of DEPTH entries. Valid bits sit in flops with a
// parallel clear, so a whole-array flush takes one edge. The payload has
// no reset and only matters while its valid bit is set. Assumes the caller
// never asks for a write and a flush in the same cycle with the write
// expected to survive: a flush wins.
module ctx_ibtb_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8,
    parameter int TGT_W = 32,
    parameter int TID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic             wr_kmode,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    output logic             rd_kmode,
    output logic [TID_W-1:0] rd_tid
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q   [DEPTH];
    logic [TGT_W-1:0] tgt_q   [DEPTH];
    logic             kmode_q [DEPTH];
    logic [TID_W-1:0] tid_q   [DEPTH];

    // Valid bits: reset and flush clear all, a write sets one.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Payload: captured on a write that is not cancelled by a flush.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en && !flush) begin
            tag_q[wr_idx]   <= wr_tag;
            tgt_q[wr_idx]   <= wr_tgt;
            kmode_q[wr_idx] <= wr_kmode;
            tid_q[wr_idx]   <= wr_tid;
        end
    end

    // Read port: asynchronous select of the indexed entry.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
        rd_kmode = kmode_q[rd_idx];
        rd_tid   = tid_q[rd_idx];
    end
endmodule

// File: rtl/ctx_ibtb_match.sv
// Hit decision for one lookup.
// Compares the read entry against the lookup tag and context. A flush in
// the same cycle masks the hit. A miss forces the target to zero.
module ctx_ibtb_match #(
    parameter int TAG_W = 8,
    parameter int TGT_W = 32,
    parameter int TID_W = 1
) (
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [TGT_W-1:0] rd_tgt,
    input  logic             rd_kmode,
    input  logic [TID_W-1:0] rd_tid,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             lk_kmode,
    input  logic [TID_W-1:0] lk_tid,
    input  logic             mode_chk,
    input  logic             thread_chk,
    input  logic             flush,
    output logic             hit,
    output logic [TGT_W-1:0] target
);
    logic tag_ok, mode_ok, thread_ok;

    // Per-field agreement; a disabled context check always agrees.
    always_comb begin
        tag_ok    = (rd_tag == lk_tag);
        mode_ok   = !mode_chk   || (rd_kmode == lk_kmode);
        thread_ok = !thread_chk || (rd_tid == lk_tid);
    end

    // Final hit and zeroed target on a miss.
    always_comb begin
        hit    = rd_valid && tag_ok && mode_ok && thread_ok && !flush;
        target = hit ? rd_tgt : '0;
    end
endmodule

// File: rtl/ctx_ibtb.sv
// Context-tagged indirect branch target buffer, top level.
// Splits PCs into index and tag, routes the update port into storage, and
// joins the control and match logic. Lookups are combinational from the
// stored state. Assumes PCs are at least 4-byte aligned (bits below IDX_LSB
// are ignored).
module ctx_ibtb
    import ctx_ibtb_pkg::*;
#(
    parameter int          PC_W    = 32,
    parameter int          TGT_W   = 32,
    parameter int          IDX_W   = 4,
    parameter int          TAG_W   = 8,
    parameter int          IDX_LSB = 2,
    parameter int          TID_W   = 1,
    parameter iso_policy_e POLICY  = ISO_CFG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic             lk_kmode,
    input  logic [TID_W-1:0] lk_tid,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic             up_en,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [TGT_W-1:0] up_target,
    input  logic             up_kmode,
    input  logic [TID_W-1:0] up_tid,
    input  logic             ctx_switch,
    input  logic             sw_barrier,
    input  logic             cfg_mode_iso,
    input  logic             cfg_thread_iso,
    input  logic             cfg_switch_flush_en
);
    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             flush, mode_chk, thread_chk;
    logic             rd_valid, rd_kmode;
    logic [TAG_W-1:0] rd_tag;
    logic [TGT_W-1:0] rd_tgt;
    logic [TID_W-1:0] rd_tid;
    logic             unused_pc_bits;

    // PC field extraction for both ports.
    always_comb begin
        lk_idx = lk_pc[IDX_LSB +: IDX_W];
        lk_tag = lk_pc[TAG_LSB +: TAG_W];
        up_idx = up_pc[IDX_LSB +: IDX_W];
        up_tag = up_pc[TAG_LSB +: TAG_W];
    end

    assign unused_pc_bits = ^{lk_pc[IDX_LSB-1:0], lk_pc[PC_W-1:TAG_MSB+1],
                              up_pc[IDX_LSB-1:0], up_pc[PC_W-1:TAG_MSB+1]};

    ctx_ibtb_ctl #(.POLICY(POLICY)) u_ctl (
        .cfg_mode_iso        (cfg_mode_iso),
        .cfg_thread_iso      (cfg_thread_iso),
        .cfg_switch_flush_en (cfg_switch_flush_en),
        .ctx_switch          (ctx_switch),
        .sw_barrier          (sw_barrier),
        .flush               (flush),
        .mode_chk            (mode_chk),
        .thread_chk          (thread_chk)
    );

    ctx_ibtb_store #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W), .TID_W(TID_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (up_en),
        .wr_idx   (up_idx),
        .wr_tag   (up_tag),
        .wr_tgt   (up_target),
        .wr_kmode (up_kmode),
        .wr_tid   (up_tid),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_kmode (rd_kmode),
        .rd_tid   (rd_tid)
    );

    ctx_ibtb_match #(
        .TAG_W(TAG_W), .TGT_W(TGT_W), .TID_W(TID_W)
    ) u_match (
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_tgt     (rd_tgt),
        .rd_kmode   (rd_kmode),
        .rd_tid     (rd_tid),
        .lk_tag     (lk_tag),
        .lk_kmode   (lk_kmode),
        .lk_tid     (lk_tid),
        .mode_chk   (mode_chk),
        .thread_chk (thread_chk),
        .flush      (flush),
        .hit        (lk_hit),
        .target     (lk_target)
    );
endmodule

// File: rtl/ctx_ibtb_chk.sv
// Property checker for ctx_ibtb, attached by bind below.
// Relates the ports to the storage read-out. Assumes configuration and
// flush inputs are valid for the whole cycle they are sampled in.
module ctx_ibtb_chk #(
    parameter int TAG_W = 8,
    parameter int TGT_W = 32,
    parameter int TID_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAG_W-1:0] lk_tag,
    input logic             lk_kmode,
    input logic [TID_W-1:0] lk_tid,
    input logic             lk_hit,
    input logic [TGT_W-1:0] lk_target,
    input logic             ctx_switch,
    input logic             sw_barrier,
    input logic             cfg_mode_iso,
    input logic             cfg_thread_iso,
    input logic             cfg_switch_flush_en,
    input logic [TAG_W-1:0] rd_tag,
    input logic             rd_kmode,
    input logic [TID_W-1:0] rd_tid
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_hit);
    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == '0));
    // R2
    hit_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (rd_tag == lk_tag));
    // R4
    mode_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && cfg_mode_iso) |-> (rd_kmode == lk_kmode));
    // R5
    thread_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && cfg_thread_iso) |-> (rd_tid == lk_tid));
    // R7
    barrier_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_barrier |-> !lk_hit);
    // R7 R9
    barrier_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_barrier) |-> !lk_hit);
    // R8 R9
    switch_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctx_switch && cfg_switch_flush_en) |-> !lk_hit);
endmodule

bind ctx_ibtb ctx_ibtb_chk #(
    .TAG_W(TAG_W), .TGT_W(TGT_W), .TID_W(TID_W)
) u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .lk_tag              (lk_tag),
    .lk_kmode            (lk_kmode),
    .lk_tid              (lk_tid),
    .lk_hit              (lk_hit),
    .lk_target           (lk_target),
    .ctx_switch          (ctx_switch),
    .sw_barrier          (sw_barrier),
    .cfg_mode_iso        (cfg_mode_iso),
    .cfg_thread_iso      (cfg_thread_iso),
    .cfg_switch_flush_en (cfg_switch_flush_en),
    .rd_tag              (rd_tag),
    .rd_kmode            (rd_kmode),
    .rd_tid              (rd_tid)
);

// File: tb/ctx_ibtb_test.sv
// Bench for ctx_ibtb: directed isolation and flush cases, then seeded
// random traffic, all compared against a bench-side reference array.
module ctx_ibtb_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_kmode = 1'b0;
    logic        lk_tid = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        up_en = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_target = '0;
    logic        up_kmode = 1'b0;
    logic        up_tid = 1'b0;
    logic        ctx_switch = 1'b0;
    logic        sw_barrier = 1'b0;
    logic        cfg_mode_iso = 1'b1;
    logic        cfg_thread_iso = 1'b1;
    logic        cfg_switch_flush_en = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference array.
    logic        m_v   [16];
    logic [7:0]  m_tag [16];
    logic [31:0] m_tgt [16];
    logic        m_k   [16];
    logic        m_t   [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_ibtb uut (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_kmode(lk_kmode), .lk_tid(lk_tid),
        .lk_hit(lk_hit), .lk_target(lk_target),
        .up_en(up_en), .up_pc(up_pc), .up_target(up_target),
        .up_kmode(up_kmode), .up_tid(up_tid),
        .ctx_switch(ctx_switch), .sw_barrier(sw_barrier),
        .cfg_mode_iso(cfg_mode_iso), .cfg_thread_iso(cfg_thread_iso),
        .cfg_switch_flush_en(cfg_switch_flush_en)
    );

    function automatic logic [31:0] mkpc(input logic [7:0] tag, input logic [3:0] idx);
        return {18'd0, tag, idx, 2'b00};
    endfunction

    function automatic logic flush_now();
        return sw_barrier | (ctx_switch & cfg_switch_flush_en);
    endfunction

    // Expected lookup result from the reference array and current inputs.
    function automatic void model_lookup(output logic h, output logic [31:0] t);
        int i = int'(lk_pc[5:2]);
        h = m_v[i] && (m_tag[i] == lk_pc[13:6])
            && (!cfg_mode_iso || m_k[i] == lk_kmode)
            && (!cfg_thread_iso || m_t[i] == lk_tid)
            && !flush_now();
        t = h ? m_tgt[i] : 32'd0;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
    endtask

    task automatic check(input string req, input logic eh, input logic [31:0] et);
        n_chk++;
        if (lk_hit !== eh || lk_target !== et) begin
            n_fail++;
            $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
                     req, lk_hit, lk_target, eh, et);
        end
    endtask

    // One cycle: inputs already set at the falling edge. Sample, then
    // advance the reference at the rising edge, and return at the next falling edge.
    task automatic run_cycle(input string req);
        logic eh;
        logic [31:0] et;
        #(CLK_PERIOD/4);
        model_lookup(eh, et);
        check(req, eh, et);
        @(posedge clk);
        if (flush_now()) begin
            model_clear();
        end else if (up_en) begin
            m_v[up_pc[5:2]]   = 1'b1;
            m_tag[up_pc[5:2]] = up_pc[13:6];
            m_tgt[up_pc[5:2]] = up_target;
            m_k[up_pc[5:2]]   = up_kmode;
            m_t[up_pc[5:2]]   = up_tid;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        up_en = 1'b0; ctx_switch = 1'b0; sw_barrier = 1'b0;
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] tgt,
                         input logic k, input logic t);
        up_en = 1'b1; up_pc = pc; up_target = tgt; up_kmode = k; up_tid = t;
    endtask

    task automatic look(input logic [31:0] pc, input logic k, input logic t);
        lk_pc = pc; lk_kmode = k; lk_tid = t;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pb;
        void'($urandom(32'h5eed_1423));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pa = mkpc(8'h11, 4'd3);
        pb = mkpc(8'h22, 4'd3);

        // R1: empty after reset.
        look(pa, 1'b0, 1'b0);
        run_cycle("R1");
        // R10: same-cycle update is not yet visible.
        train(pa, 32'h1000_0040, 1'b0, 1'b0);
        run_cycle("R10");
        quiet();
        // R3: trained entry hits next cycle.
        run_cycle("R3");
        // R4: kernel lookup of user-trained entry misses.
        look(pa, 1'b1, 1'b0);
        run_cycle("R4");
        // R6: privilege check off lets it hit.
        cfg_mode_iso = 1'b0;
        run_cycle("R6");
        cfg_mode_iso = 1'b1;
        // R5: other thread misses.
        look(pa, 1'b0, 1'b1);
        run_cycle("R5");
        // R6: thread check off lets it hit.
        cfg_thread_iso = 1'b0;
        run_cycle("R6");
        cfg_thread_iso = 1'b1;
        // R2: same index, different tag misses.
        look(pb, 1'b0, 1'b0);
        run_cycle("R2");
        // R3: overwrite with a new context and target.
        train(pa, 32'h2000_0080, 1'b1, 1'b1);
        look(pa, 1'b1, 1'b1);
        run_cycle("R10");
        quiet();
        run_cycle("R3");
        look(pa, 1'b0, 1'b0);
        run_cycle("R4");
        // R8: transition with flush disabled has no effect.
        look(pa, 1'b1, 1'b1);
        cfg_switch_flush_en = 1'b0;
        ctx_switch = 1'b1;
        run_cycle("R8");
        quiet();
        run_cycle("R8");
        // R8: enabled transition clears, same cycle and after.
        cfg_switch_flush_en = 1'b1;
        ctx_switch = 1'b1;
        run_cycle("R8");
        quiet();
        run_cycle("R8");
        // R9: update during a barrier is dropped.
        train(pb, 32'h3000_00c0, 1'b0, 1'b0);
        sw_barrier = 1'b1;
        look(pb, 1'b0, 1'b0);
        run_cycle("R9");
        quiet();
        run_cycle("R9");
        // R7: barrier clears a live entry.
        train(pb, 32'h4000_0100, 1'b0, 1'b0);
        run_cycle("R3");
        quiet();
        run_cycle("R3");
        sw_barrier = 1'b1;
        run_cycle("R7");
        quiet();
        run_cycle("R7");

        // Random traffic.
        for (int n = 0; n < N_RAND; n++) begin
            logic [7:0] tg;
            tg = ($urandom % 2 == 0) ? 8'h11 : 8'h22;
            look(mkpc(tg, 4'($urandom)), 1'($urandom), 1'($urandom));
            up_en = ($urandom % 3 == 0);
            tg = ($urandom % 2 == 0) ? 8'h11 : 8'h22;
            up_pc = mkpc(tg, 4'($urandom));
            up_target = $urandom;
            up_kmode = 1'($urandom);
            up_tid = 1'($urandom);
            sw_barrier = ($urandom % 60 == 0);
            ctx_switch = ($urandom % 40 == 0);
            if ($urandom % 50 == 0) cfg_mode_iso = 1'($urandom);
            if ($urandom % 50 == 0) cfg_thread_iso = 1'($urandom);
            if ($urandom % 50 == 0) cfg_switch_flush_en = 1'($urandom);
            run_cycle("R2 R4 R5 R6 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule